// File: doc/BRIEF.md
# Mode-Selectable Multiply-Accumulate Unit

An unsigned arithmetic cell for signal-processing datapaths. It takes two 8-bit operands `a` and `b`, a 16-bit `addend` and a 3-bit operation code. From these it forms a product, a product plus the addend, an operand plus the addend, a running sum of addends, or a running sum of products. Each operation has a combinational flavour, where the result appears on `y` in the same cycle, or a registered flavour, where `y` comes from a register loaded at the clock edge. One multiply-accumulate step completes in each cycle.

The operation code may change on any cycle. No reset is needed between modes. A 20-bit accumulator holds the running sum. A separate 20-bit output register holds the result of the registered modes. The output register also captures the combinational result on every enabled edge, so a switch to a registered mode sees a current value. A synchronous clear empties both registers, and a low enable freezes both.

Top module: `mac_cell`

## Requirements
- R1: Code 3'b000 drives `y` combinationally with `a*b`, zero-extended to 20 bits.
- R2: Code 3'b001 drives `y` combinationally with `a*b + addend`.
- R3: Code 3'b011 drives `y` combinationally with `a + addend`.
- R4: Codes 3'b100, 3'b101 and 3'b111 compute `a*b`, `a*b + addend` and `a + addend` from the inputs seen at a clock edge. They present that value on `y` after the edge and hold it until the next enabled edge.
- R5: Code 3'b010 adds `addend` to the accumulator at each enabled edge, and `y` shows the accumulator.
- R6: Code 3'b110 adds `a*b` to the accumulator at each enabled edge, and `y` shows the accumulator.
- R7: Accumulator arithmetic wraps modulo 2^20.
- R8: `clr` high at an edge zeroes the accumulator and the output register, whatever the value of `en`.
- R9: `en` low with `clr` low holds both registers unchanged.
- R10: On entry to code 3'b010 or 3'b110, accumulation continues from the value already in the accumulator. The non-accumulating codes leave the accumulator untouched.
- R11: In the combinational codes, an enabled edge loads the combinational result into the output register.
- R12: Asynchronous active-low `rst_n` zeroes both registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of both registers |
| en | input | 1 | Register update enable |
| mode | input | 3 | Operation code |
| a | input | 8 | Operand A, unsigned |
| b | input | 8 | Operand B, unsigned |
| addend | input | 16 | Addend, unsigned |
| y | output | 20 | Result |

## Verification
The bench builds two copies of the cell with the default widths (8-bit operands, 16-bit addend, 20-bit accumulator). One copy uses the inferred multiplier and the other uses the generated partial-product array. Every check compares both copies against the same expected value, so both multiplier variants are covered. With 20-bit wrap, seventeen all-ones products carry the accumulator past 2^20 within a short run. The wrap boundary and full-scale operand sums are therefore checked directly.

// File: rtl/mac_cell_pkg.sv
package mac_cell_pkg;
   typedef enum logic [2:0] {
      OP_MUL      = 3'b000,
      OP_MULADD   = 3'b001,
      OP_ACC      = 3'b010,
      OP_ADD      = 3'b011,
      OP_MUL_R    = 3'b100,
      OP_MULADD_R = 3'b101,
      OP_MAC      = 3'b110,
      OP_ADD_R    = 3'b111
   } op_e;

   function automatic logic op_accumulates(op_e op);
      return (op == OP_ACC) || (op == OP_MAC);
   endfunction

   function automatic logic op_combinational(op_e op);
      return (op == OP_MUL) || (op == OP_MULADD) || (op == OP_ADD);
   endfunction
endpackage

// File: rtl/mac_cell_mult.sv
module mac_cell_mult #(
   parameter int OPW        = 8,
   parameter bit ARRAY_MULT = 1'b0
) (
   input  logic [OPW-1:0]   a,
   input  logic [OPW-1:0]   b,
   output logic [2*OPW-1:0] p
);
   localparam int PW = 2 * OPW;

   if (ARRAY_MULT) begin : g_array
      logic [PW-1:0] pp [OPW];
      for (genvar i = 0; i < OPW; i++) begin : g_pp
         assign pp[i] = b[i] ? (PW'(a) << i) : '0;
      end
      always_comb begin
         p = '0;
         for (int i = 0; i < OPW; i++) p = p + pp[i];
      end
   end else begin : g_infer
      assign p = PW'(a) * PW'(b);
   end
endmodule

// File: rtl/mac_cell_arith.sv
module mac_cell_arith
   import mac_cell_pkg::*;
#(
   parameter int OPW  = 8,
   parameter int ADDW = 16,
   parameter int ACCW = 20
) (
   input  op_e              op,
   input  logic [OPW-1:0]   a,
   input  logic [2*OPW-1:0] prod,
   input  logic [ADDW-1:0]  addend,
   input  logic [ACCW-1:0]  acc_q,
   output logic [ACCW-1:0]  res
);
   logic [ACCW-1:0] prod_x, add_x, a_x;

   assign prod_x = ACCW'(prod);
   assign add_x  = ACCW'(addend);
   assign a_x    = ACCW'(a);

   always_comb begin
      unique case (op)
         OP_MUL,    OP_MUL_R:    res = prod_x;
         OP_MULADD, OP_MULADD_R: res = prod_x + add_x;
         OP_ADD,    OP_ADD_R:    res = a_x + add_x;
         OP_ACC:                 res = acc_q + add_x;
         OP_MAC:                 res = acc_q + prod_x;
         default:                res = '0;
      endcase
   end
endmodule

// File: rtl/mac_cell_regs.sv
module mac_cell_regs #(
   parameter int ACCW = 20
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            en,
   input  logic            load_acc,
   input  logic [ACCW-1:0] res,
   output logic [ACCW-1:0] acc_q,
   output logic [ACCW-1:0] out_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         out_q <= '0;
      end else if (clr) begin
         acc_q <= '0;
         out_q <= '0;
      end else if (en) begin
         out_q <= res;
         if (load_acc) acc_q <= res;
      end
   end
endmodule

// File: rtl/mac_cell.sv
module mac_cell
   import mac_cell_pkg::*;
#(
   parameter int OPW        = 8,
   parameter int ADDW       = 16,
   parameter int ACCW       = 20,
   parameter bit ARRAY_MULT = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            en,
   input  logic [2:0]      mode,
   input  logic [OPW-1:0]  a,
   input  logic [OPW-1:0]  b,
   input  logic [ADDW-1:0] addend,
   output logic [ACCW-1:0] y
);
   localparam int PW = 2 * OPW;

   if (OPW < 1) begin : g_bad_opw
      $error("mac_cell: OPW must be at least 1");
   end
   if (ACCW < PW + 1) begin : g_bad_accw
      $error("mac_cell: ACCW must exceed the product width");
   end
   if (ADDW > ACCW || ADDW < OPW) begin : g_bad_addw
      $error("mac_cell: ADDW must lie between OPW and ACCW");
   end

   op_e             op;
   logic [PW-1:0]   prod;
   logic [ACCW-1:0] res, acc_q, out_q;

   assign op = op_e'(mode);

   mac_cell_mult #(.OPW(OPW), .ARRAY_MULT(ARRAY_MULT)) u_mult (
      .a (a), .b (b), .p (prod)
   );

   mac_cell_arith #(.OPW(OPW), .ADDW(ADDW), .ACCW(ACCW)) u_arith (
      .op (op), .a (a), .prod (prod), .addend (addend),
      .acc_q (acc_q), .res (res)
   );

   mac_cell_regs #(.ACCW(ACCW)) u_regs (
      .clk (clk), .rst_n (rst_n), .clr (clr), .en (en),
      .load_acc (op_accumulates(op)), .res (res),
      .acc_q (acc_q), .out_q (out_q)
   );

   always_comb begin
      if (op_combinational(op))     y = res;
      else if (op_accumulates(op))  y = acc_q;
      else                          y = out_q;
   end
endmodule

// File: rtl/mac_cell_chk.sv
module mac_cell_chk #(
   parameter int OPW        = 8,
   parameter int ADDW       = 16,
   parameter int ACCW       = 20,
   parameter bit ARRAY_MULT = 1'b0
) (
   input logic            clk,
   input logic            rst_n,
   input logic            clr,
   input logic            en,
   input logic [2:0]      mode,
   input logic [OPW-1:0]  a,
   input logic [OPW-1:0]  b,
   input logic [ADDW-1:0] addend,
   input logic [ACCW-1:0] y
);
   logic regsrc;
   assign regsrc = mode[2] || (mode == 3'b010);

   // R1
   assert_comb_mul_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'b000) |-> (y == ACCW'(a) * ACCW'(b)));

   // R2
   assert_comb_muladd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'b001) |-> (y == ACCW'(a) * ACCW'(b) + ACCW'(addend)));

   // R3
   assert_comb_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'b011) |-> (y == ACCW'(a) + ACCW'(addend)));

   // R4
   assert_reg_mul_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'b100 && en && !clr) ##1 (mode == 3'b100)
      |-> (y == ACCW'($past(a)) * ACCW'($past(b))));

   // R5 and R7
   assert_acc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'b010 && en && !clr) ##1 (mode == 3'b010)
      |-> (y == ACCW'($past(y) + ACCW'($past(addend)))));

   // R6 and R7
   assert_mac_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'b110 && en && !clr) ##1 (mode == 3'b110)
      |-> (y == ACCW'($past(y) + ACCW'($past(a)) * ACCW'($past(b)))));

   // R8
   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!regsrc || (y == '0)));

   // R9
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) ##1 (regsrc && mode == $past(mode)) |-> $stable(y));
endmodule

bind mac_cell mac_cell_chk #(
   .OPW(OPW), .ADDW(ADDW), .ACCW(ACCW), .ARRAY_MULT(ARRAY_MULT)
) u_chk (.*);

// File: tb/mac_cell_tb.sv
module mac_cell_tb;
   localparam int OPW  = 8;
   localparam int ADDW = 16;
   localparam int ACCW = 20;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            clr = 1'b0;
   logic            en = 1'b0;
   logic [2:0]      mode = 3'b000;
   logic [OPW-1:0]  a = '0;
   logic [OPW-1:0]  b = '0;
   logic [ADDW-1:0] addend = '0;
   logic [ACCW-1:0] y, y_alt;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   mac_cell #(.OPW(OPW), .ADDW(ADDW), .ACCW(ACCW), .ARRAY_MULT(1'b0)) u_dut (
      .clk (clk), .rst_n (rst_n), .clr (clr), .en (en), .mode (mode),
      .a (a), .b (b), .addend (addend), .y (y)
   );

   mac_cell #(.OPW(OPW), .ADDW(ADDW), .ACCW(ACCW), .ARRAY_MULT(1'b1)) u_alt (
      .clk (clk), .rst_n (rst_n), .clr (clr), .en (en), .mode (mode),
      .a (a), .b (b), .addend (addend), .y (y_alt)
   );

   task automatic check(input string req, input logic [ACCW-1:0] exp);
      checks++;
      if (y !== exp || y_alt !== exp) begin
         errors++;
         $display("FAIL %s: got %0d (array variant %0d), expected %0d", req, y, y_alt, exp);
      end
   endtask

   task automatic drive(input logic [2:0] m, input int av, input int bv,
                        input int cv, input logic e, input logic c);
      mode = m; a = OPW'(av); b = OPW'(bv); addend = ADDW'(cv); en = e; clr = c;
      #1;
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic t_reset();
      drive(3'b010, 0, 0, 0, 1'b0, 1'b0);
      check("R12 accumulator after reset", 20'd0);
      drive(3'b100, 0, 0, 0, 1'b0, 1'b0);
      check("R12 output register after reset", 20'd0);
   endtask

   task automatic t_comb();
      drive(3'b000, 200, 255, 0, 1'b0, 1'b0);
      check("R1 product", 20'd51000);
      drive(3'b000, 0, 77, 9, 1'b0, 1'b0);
      check("R1 zero operand", 20'd0);
      drive(3'b001, 255, 255, 65535, 1'b0, 1'b0);
      check("R2 full-scale product plus addend", 20'd130560);
      drive(3'b011, 17, 99, 65535, 1'b0, 1'b0);
      check("R3 operand plus addend", 20'd65552);
      drive(3'b011, 255, 0, 0, 1'b0, 1'b0);
      check("R3 operand only", 20'd255);
   endtask

   task automatic t_registered();
      drive(3'b100, 12, 13, 0, 1'b1, 1'b0);
      tick();
      check("R4 registered product", 20'd156);
      drive(3'b100, 3, 3, 0, 1'b0, 1'b0);
      check("R4 input change between edges ignored", 20'd156);
      drive(3'b101, 10, 10, 5, 1'b1, 1'b0);
      tick();
      check("R4 registered product plus addend", 20'd105);
      drive(3'b111, 255, 0, 65535, 1'b1, 1'b0);
      tick();
      check("R4 registered add", 20'd65790);
   endtask

   task automatic t_accumulate();
      drive(3'b010, 0, 0, 1000, 1'b1, 1'b1);
      tick();
      drive(3'b010, 0, 0, 1000, 1'b1, 1'b0);
      check("R8 accumulator cleared", 20'd0);
      for (int k = 1; k <= 3; k++) begin
         tick();
         check("R5 accumulate addend", ACCW'(1000 * k));
      end
   endtask

   task automatic t_mac();
      drive(3'b110, 255, 255, 0, 1'b1, 1'b1);
      tick();
      drive(3'b110, 255, 255, 0, 1'b1, 1'b0);
      for (int k = 1; k <= 17; k++) begin
         tick();
         if (k == 1)  check("R6 first product accumulated", 20'd65025);
         if (k == 16) check("R6 sixteen products accumulated", 20'd1040400);
         if (k == 17) check("R7 wrap modulo 2^20", 20'd56849);
      end
   endtask

   task automatic t_hold();
      drive(3'b110, 255, 255, 0, 1'b0, 1'b0);
      tick();
      tick();
      check("R9 accumulator held with enable low", 20'd56849);
      drive(3'b100, 1, 1, 0, 1'b0, 1'b0);
      tick();
      check("R9 output register held with enable low", 20'd56849);
   endtask

   task automatic t_resume();
      drive(3'b000, 2, 3, 0, 1'b1, 1'b0);
      tick();
      drive(3'b011, 4, 0, 8, 1'b1, 1'b0);
      tick();
      drive(3'b010, 0, 0, 5, 1'b1, 1'b0);
      check("R10 accumulator untouched by other codes", 20'd56849);
      tick();
      check("R10 accumulation resumes from held value", 20'd56854);
   endtask

   task automatic t_comb_capture();
      drive(3'b000, 9, 9, 0, 1'b1, 1'b0);
      tick();
      drive(3'b100, 1, 1, 0, 1'b0, 1'b0);
      check("R11 combinational result captured", 20'd81);
   endtask

   task automatic t_clear_priority();
      drive(3'b110, 7, 7, 0, 1'b0, 1'b1);
      tick();
      drive(3'b110, 7, 7, 0, 1'b0, 1'b0);
      check("R8 clear beats low enable, accumulator", 20'd0);
      drive(3'b100, 7, 7, 0, 1'b0, 1'b0);
      check("R8 clear beats low enable, output register", 20'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_comb();
      t_registered();
      t_accumulate();
      t_mac();
      t_hold();
      t_resume();
      t_comb_capture();
      t_clear_priority();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(8 * 5000);
      if (!finished) begin
         finished = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule